// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Read-to-Write Turnaround

This block turns requests from a CPU-side port into cycles on an external asynchronous memory bus. It drives the bus address, one active-low select per memory area, an active-low read strobe, an active-low write strobe, the write data and its output enable. Each access steps through numbered bus states. A read takes three states, T1 to T3. A write takes two states, T1 and T2. A new request can be accepted in the last state of the running cycle, so cycles can follow one another with no gap.

Some slow devices keep driving the shared data lines for a while after their read strobe goes away. If a write is sent straight after a read, the CPU's write data can collide with the device's late read data. To avoid this, the block keeps a record of the type of the running access. When a write is accepted directly behind a read and the turnaround control bit is 1, the block puts one idle state (TI) in front of the write's T1. During TI nothing on the bus is active. The control bit is 1 after reset. Insertion depends only on the read-then-write order; it does not matter whether the area changes.

Top module: `xbus_seq`

## Requirements
- R1: After reset, every area select, the read strobe and the write strobe are high, the data output enable and the done pulse are low, request ready is high, and the turnaround bit is 1.
- R2: A read occupies exactly three consecutive bus states. In all three, the selected area's select and the read strobe are low, the write strobe is high, the output enable is low, and the bus address equals the request address.
- R3: A write occupies exactly two consecutive bus states. The output enable is high and the write data is on the bus in both. The write strobe is low only in the second state, and the read strobe stays high.
- R4: When a write is accepted in the last state of a read and the turnaround bit is 1, exactly one idle state follows the read. In that state all selects and both strobes are high and the output enable is low. The write's first state comes after it.
- R5: With the turnaround bit at 0, a write accepted in the last state of a read begins in the very next state, with no idle state.
- R6: Back-to-back read after read, write after write, and read after write never get an idle state. The next cycle's first state directly follows the previous cycle's last state.
- R7: Whether the idle state is inserted depends only on the read-then-write order. It behaves the same whether or not the write's area differs from the read's.
- R8: When no cycle is running, the record of the previous access is cleared. A write started from the no-cycle state never gets an idle state, so the number of quiet states before it equals the time the bus spent with no cycle.
- R9: `rsp_done_o` is high for exactly one clock, in the state after the last state of every cycle. For a read, `rsp_rdata_o` then holds the value of `bus_din_i` sampled in the read's last state.
- R10: `req_ready_o` is high in the no-cycle state and in the last state of a cycle, and low in every other state. A request is taken at a clock edge where `req_valid_i` and `req_ready_o` are both high.
- R11: At most one select is low at a time. Area index k, given in binary on `req_area_i`, drives bit k of `bus_cs_no` low.
- R12: A clock edge with `cfg_we_i` high loads `cfg_idle_i` into the turnaround bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the turnaround bit |
| cfg_idle_i | input | 1 | New value of the turnaround bit |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address |
| req_area_i | input | AREA_W | Target area index (binary) |
| req_wdata_i | input | DW | Write data |
| rsp_done_o | output | 1 | One-clock pulse after each cycle's last state |
| rsp_rdata_o | output | DW | Data captured by the last read |
| bus_addr_o | output | AW | External address |
| bus_cs_no | output | N_AREA | Area selects, active low |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_wr_no | output | 1 | Write strobe, active low |
| bus_dout_o | output | DW | Write data to the bus |
| bus_doe_o | output | 1 | Write data output enable |
| bus_din_i | input | DW | Read data from the bus |

## Verification
The hardest case to reach from the ports is a write that is accepted exactly in T3 of a read. Only that case can produce the idle state; one clock later the bus is already in the no-cycle state and the record is gone. To get there, the driver presents the next request as soon as the previous one is taken and holds it valid until ready rises, so every chained request lands in the final state of the cycle before it. That stimulus is set against requests issued after a measured number of quiet states. The monitor then splits the bus activity into cycles using the expected lengths, counts the quiet states between cycles, and checks that count against the expected one.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    ST_NONE = 3'd0,
    ST_TI   = 3'd1,
    ST_T1   = 3'd2,
    ST_T2   = 3'd3,
    ST_T3   = 3'd4
  } bus_st_e;

  function automatic logic is_last(bus_st_e st, logic we);
    return (st == ST_T3) || (st == ST_T2 && we);
  endfunction

  function automatic logic in_access(bus_st_e st);
    return (st == ST_T1) || (st == ST_T2) || (st == ST_T3);
  endfunction
endpackage

// File: rtl/xbus_turn.sv
module xbus_turn (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_we_i,
  input  logic cfg_idle_i,
  input  logic accept_i,
  input  logic acc_we_i,
  input  logic cyc_last_i,
  input  logic bus_free_i,
  output logic ins_idle_o,
  output logic idle_en_o
);
  logic idle_en_q;
  logic rec_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_en_q <= 1'b1;
    else if (cfg_we_i) idle_en_q <= cfg_idle_i;
  end

  // record of the type of the access in flight; cleared with the bus idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rec_rd_q <= 1'b0;
    else if (accept_i) rec_rd_q <= ~acc_we_i;
    else if (bus_free_i) rec_rd_q <= 1'b0;
  end

  assign ins_idle_o = idle_en_q & accept_i & acc_we_i & rec_rd_q & cyc_last_i;
  assign idle_en_o  = idle_en_q;
endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm #(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int AREA_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_we_i,
  input  logic [AW-1:0]        req_addr_i,
  input  logic [AREA_W-1:0]    req_area_i,
  input  logic [DW-1:0]        req_wdata_i,
  input  logic                 ins_idle_i,
  input  logic [DW-1:0]        bus_din_i,
  output logic                 req_ready_o,
  output logic                 accept_o,
  output logic                 cyc_last_o,
  output logic                 bus_free_o,
  output xbus_pkg::bus_st_e    st_o,
  output logic                 we_o,
  output logic [AW-1:0]        addr_o,
  output logic [AREA_W-1:0]    area_o,
  output logic [DW-1:0]        wdata_o,
  output logic                 done_o,
  output logic [DW-1:0]        rdata_o
);
  import xbus_pkg::*;

  bus_st_e           st_q, st_d;
  logic              we_q;
  logic [AW-1:0]     addr_q;
  logic [AREA_W-1:0] area_q;
  logic [DW-1:0]     wdata_q;
  logic              done_q;
  logic [DW-1:0]     rdata_q;
  logic              last;
  logic              accept;

  assign last        = is_last(st_q, we_q);
  assign req_ready_o = (st_q == ST_NONE) || last;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_NONE: if (accept) st_d = ST_T1;
      ST_TI:   st_d = ST_T1;
      ST_T1:   st_d = ST_T2;
      ST_T2:   begin
        if (!we_q) st_d = ST_T3;
        else if (accept) st_d = ins_idle_i ? ST_TI : ST_T1;
        else st_d = ST_NONE;
      end
      ST_T3:   begin
        if (accept) st_d = ins_idle_i ? ST_TI : ST_T1;
        else st_d = ST_NONE;
      end
      default: st_d = ST_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_NONE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      area_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        we_q    <= req_we_i;
        addr_q  <= req_addr_i;
        area_q  <= req_area_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= last;
      if (last && !we_q) rdata_q <= bus_din_i;
    end
  end

  assign accept_o   = accept;
  assign cyc_last_o = last;
  assign bus_free_o = (st_q == ST_NONE);
  assign st_o       = st_q;
  assign we_o       = we_q;
  assign addr_o     = addr_q;
  assign area_o     = area_q;
  assign wdata_o    = wdata_q;
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/xbus_cs_dec.sv
module xbus_cs_dec #(
  parameter int N_AREA = 8,
  parameter int AREA_W = 3
) (
  input  logic              en_i,
  input  logic [AREA_W-1:0] area_i,
  output logic [N_AREA-1:0] cs_no
);
  for (genvar i = 0; i < N_AREA; i++) begin : g_cs
    assign cs_no[i] = ~(en_i && (area_i == AREA_W'(i)));
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int  AW     = 16,
  parameter int  DW     = 16,
  parameter int  N_AREA = 8,
  localparam int AREA_W = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_idle_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [AREA_W-1:0] req_area_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_done_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [N_AREA-1:0] bus_cs_no,
  output logic              bus_rd_no,
  output logic              bus_wr_no,
  output logic [DW-1:0]     bus_dout_o,
  output logic              bus_doe_o,
  input  logic [DW-1:0]     bus_din_i
);
  import xbus_pkg::*;

  bus_st_e           st_q;
  logic              accept, cyc_last, bus_free, ins_idle, idle_en;
  logic              we_q;
  logic [AREA_W-1:0] area_q;
  logic              acc;

  xbus_fsm #(.AW(AW), .DW(DW), .AREA_W(AREA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_area_i  (req_area_i),
    .req_wdata_i (req_wdata_i),
    .ins_idle_i  (ins_idle),
    .bus_din_i   (bus_din_i),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .cyc_last_o  (cyc_last),
    .bus_free_o  (bus_free),
    .st_o        (st_q),
    .we_o        (we_q),
    .addr_o      (bus_addr_o),
    .area_o      (area_q),
    .wdata_o     (bus_dout_o),
    .done_o      (rsp_done_o),
    .rdata_o     (rsp_rdata_o)
  );

  xbus_turn u_turn (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_idle_i (cfg_idle_i),
    .accept_i   (accept),
    .acc_we_i   (req_we_i),
    .cyc_last_i (cyc_last),
    .bus_free_i (bus_free),
    .ins_idle_o (ins_idle),
    .idle_en_o  (idle_en)
  );

  assign acc = in_access(st_q);

  xbus_cs_dec #(.N_AREA(N_AREA), .AREA_W(AREA_W)) u_cs (
    .en_i   (acc),
    .area_i (area_q),
    .cs_no  (bus_cs_no)
  );

  assign bus_rd_no = ~(acc && !we_q);
  assign bus_wr_no = ~(we_q && st_q == ST_T2);
  assign bus_doe_o = we_q && (st_q == ST_T1 || st_q == ST_T2);
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int N_AREA = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_AREA-1:0] bus_cs_no,
  input logic              bus_rd_no,
  input logic              bus_wr_no,
  input logic              bus_doe_o,
  input logic              rsp_done_o,
  input logic              req_valid_i,
  input logic              req_we_i,
  input xbus_pkg::bus_st_e st_i,
  input logic              idle_en_i
);
  import xbus_pkg::*;

  a_r11_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~bus_cs_no));

  a_r3_doe_excl_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_doe_o |-> bus_rd_no);

  a_r4_ti_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_TI) |-> ((&bus_cs_no) && bus_rd_no && bus_wr_no && !bus_doe_o));

  a_r4_ti_to_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_TI) |=> (st_i == ST_T1 && bus_doe_o));

  a_r4_insert_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_en_i && st_i == ST_T3 && req_valid_i && req_we_i) |=> (st_i == ST_TI));

  a_r5_insert_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_en_i && st_i == ST_T3 && req_valid_i && req_we_i) |=> (st_i == ST_T1));

  a_r6_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_T2 && bus_doe_o && req_valid_i) |=> (st_i == ST_T1));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);
endmodule

bind xbus_seq xbus_seq_chk #(.N_AREA(N_AREA)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_cs_no   (bus_cs_no),
  .bus_rd_no   (bus_rd_no),
  .bus_wr_no   (bus_wr_no),
  .bus_doe_o   (bus_doe_o),
  .rsp_done_o  (rsp_done_o),
  .req_valid_i (req_valid_i),
  .req_we_i    (req_we_i),
  .st_i        (st_q),
  .idle_en_i   (idle_en)
);

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] DIN_MASK = 16'hA5C3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_idle_i = 1'b0;
  logic        req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [15:0] req_addr_i = '0, req_wdata_i = '0;
  logic [2:0]  req_area_i = '0;
  logic        req_ready_o, rsp_done_o, bus_rd_no, bus_wr_no, bus_doe_o;
  logic [15:0] rsp_rdata_o, bus_addr_o, bus_dout_o, bus_din_i;
  logic [7:0]  bus_cs_no;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign bus_din_i = bus_addr_o ^ DIN_MASK;

  xbus_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_idle_i(cfg_idle_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_area_i(req_area_i), .req_wdata_i(req_wdata_i),
    .rsp_done_o(rsp_done_o), .rsp_rdata_o(rsp_rdata_o), .bus_addr_o(bus_addr_o),
    .bus_cs_no(bus_cs_no), .bus_rd_no(bus_rd_no), .bus_wr_no(bus_wr_no),
    .bus_dout_o(bus_dout_o), .bus_doe_o(bus_doe_o), .bus_din_i(bus_din_i)
  );

  typedef struct {
    bit          we;
    int          area;
    logic [15:0] addr;
    logic [15:0] wd;
    int          gap;
    bit          skip;
    string       tag;
  } item_t;

  item_t q[$];
  int    tot = 0, bad = 0;
  bit    started = 0, fin = 0;
  bit    prev_rd = 0, idle_model = 1, skip_next = 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: k==0 chains behind the running cycle, k>0 issues after k quiet states
  task automatic issue(bit we, int area, logic [15:0] addr, logic [15:0] wd, int k, string tag);
    item_t it;
    it.we = we; it.area = area; it.addr = addr; it.wd = wd; it.tag = tag;
    it.skip = skip_next;
    skip_next = 0;
    if (k > 0) begin
      req_valid_i = 1'b0;
      do @(negedge clk_i); while (!req_ready_o);
      @(negedge clk_i);
      repeat (k-1) @(negedge clk_i);
      it.gap = k;
    end else begin
      it.gap = (prev_rd && we && idle_model) ? 1 : 0;
    end
    q.push_back(it);
    req_valid_i = 1'b1; req_we_i = we; req_area_i = 3'(area);
    req_addr_i = addr; req_wdata_i = wd;
    while (!req_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    prev_rd = !we;
  endtask

  task automatic cfg(bit v);
    do @(negedge clk_i); while (!req_ready_o);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idle_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    idle_model = v;
    skip_next = 1;
  endtask

  // monitor
  logic        act;
  bit          in_cyc = 0, exp_done = 0, exp_we = 0;
  int          cnt = 0, gap = 0, len = 0;
  logic [15:0] exp_rd = '0;
  item_t       cur;

  assign act = ~&bus_cs_no;

  always @(negedge clk_i) begin
    if (rst_ni && started) begin
      if (exp_done) begin
        chk(rsp_done_o == 1'b1, "R9", "done pulse", rsp_done_o, 1);
        if (!exp_we) chk(rsp_rdata_o == exp_rd, "R9", "read data", rsp_rdata_o, exp_rd);
        exp_done = 0;
      end else if (rsp_done_o) begin
        chk(0, "R9", "stray done", 1, 0);
      end
      if (!in_cyc) begin
        if (act) begin
          if (q.size() == 0) begin
            chk(0, "R10", "unrequested cycle", 1, 0);
          end else begin
            cur = q.pop_front();
            if (!cur.skip) chk(gap == cur.gap, cur.tag, "quiet states before cycle", gap, cur.gap);
            in_cyc = 1; cnt = 0;
            len = cur.we ? 2 : 3;
          end
        end else begin
          gap++;
          if (!(bus_rd_no && bus_wr_no && !bus_doe_o))
            chk(0, "R4", "strobes in quiet state", {bus_rd_no, bus_wr_no, bus_doe_o}, 3'b110);
        end
      end
      if (in_cyc) begin
        cnt++;
        chk(bus_cs_no == ~(8'b1 << cur.area), "R11", "select", bus_cs_no, ~(8'b1 << cur.area));
        chk(bus_addr_o == cur.addr, "R2", "address", bus_addr_o, cur.addr);
        chk(req_ready_o == (cnt == len), "R10", "ready", req_ready_o, cnt == len);
        if (!cur.we) begin
          chk(!bus_rd_no && bus_wr_no && !bus_doe_o, "R2", "read strobes",
              {bus_rd_no, bus_wr_no, bus_doe_o}, 3'b010);
        end else begin
          chk(bus_rd_no && bus_doe_o && bus_dout_o == cur.wd, "R3", "write data",
              bus_dout_o, cur.wd);
          chk(bus_wr_no == (cnt != 2), "R3", "write strobe", bus_wr_no, cnt != 2);
        end
        if (cnt == len) begin
          in_cyc = 0; gap = 0;
          exp_done = 1; exp_we = cur.we; exp_rd = cur.addr ^ DIN_MASK;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!fin) begin
      tot++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
      $display("  test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(req_ready_o == 1'b1, "R1", "ready", req_ready_o, 1);
    chk(bus_cs_no == 8'hFF, "R1", "selects", bus_cs_no, 8'hFF);
    chk(bus_rd_no && bus_wr_no, "R1", "strobes", {bus_rd_no, bus_wr_no}, 2'b11);
    chk(!bus_doe_o && !rsp_done_o, "R1", "enable/done", {bus_doe_o, rsp_done_o}, 0);
    rst_ni = 1'b1;
    started = 1;
    @(negedge clk_i);

    // R1 default insertion on, R4 write after read
    issue(0, 0, 16'h0100, 16'h0,    2, "R4");
    issue(1, 0, 16'h0102, 16'h1111, 0, "R4");
    // R6 W->W, W->R, R->R
    issue(1, 1, 16'h0200, 16'h2222, 0, "R6");
    issue(0, 1, 16'h0204, 16'h0,    0, "R6");
    issue(0, 2, 16'h0300, 16'h0,    0, "R6");
    // R7 area change and same area
    issue(1, 5, 16'h0500, 16'h5555, 0, "R7");
    issue(0, 5, 16'h0504, 16'h0,    0, "R7");
    issue(1, 5, 16'h0506, 16'h6666, 0, "R7");
    // R8 write after a bus-free gap
    issue(0, 3, 16'h0700, 16'h0,    0, "R6");
    issue(1, 3, 16'h0702, 16'h7777, 2, "R8");
    issue(0, 3, 16'h0704, 16'h0,    0, "R6");
    issue(1, 4, 16'h0706, 16'h7878, 1, "R8");
    // R12 clear the bit, R5 no insertion
    cfg(1'b0);
    issue(0, 4, 16'h0800, 16'h0,    3, "R12");
    issue(1, 4, 16'h0802, 16'h8888, 0, "R5");
    issue(0, 6, 16'h0900, 16'h0,    0, "R6");
    issue(1, 7, 16'h0902, 16'h9999, 0, "R5");
    // R12 set again
    cfg(1'b1);
    issue(0, 0, 16'h0A00, 16'h0,    2, "R12");
    issue(1, 7, 16'h0A02, 16'hAAAA, 0, "R12");

    while (q.size() != 0 || in_cyc) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    fin = 1;
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule